// File: doc/BRIEF.md
# Predicated Widening Dot-Product Accumulator

This unit takes two 64-bit operand words, each packing four unsigned 16-bit lanes, and a 64-bit accumulator value. Each lane of the first operand can be switched off by a 4-bit lane mask, which forces that lane to zero. Lane pairs are multiplied after each lane is zero-extended to 64 bits. The four products are then added together at 64-bit width.

A direction flag chooses whether the lane sum is added to the accumulator or taken away from it. The result is registered, and a valid strobe follows the input valid one cycle later. The unit is meant as the inner step of a larger tile-update engine. That engine supplies one accumulator word per issue and writes back the result.

Top module: `wdot_acc`

## Requirements
- R1: Lane k (k = 0..3) occupies bits [16k+15:16k] of both operands. The result uses the sum of the four lane products.
- R2: Each lane is zero-extended before its multiply. Product 0xFFFF*0xFFFF contributes 0x00000000FFFE0001 and is never sign-extended.
- R3: Mask bit k = 0 makes lane k contribute zero, whatever the operand values are.
- R4: When the subtract flag is 1, the result is accumulator minus lane sum. Otherwise it is accumulator plus lane sum.
- R5: Arithmetic wraps modulo 2^64. There is no saturation and no overflow indication.
- R6: The result register loads on the clock edge at which inValid is 1. outValid is 1 in the cycle that follows, and 0 after a cycle without inValid.
- R7: Synchronous active-high reset clears outValid and the result register to 0.
- R8: When inValid is 0, the result register holds its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Operands present this cycle |
| opA | input | 64 | First operand, four 16-bit lanes, masked |
| opB | input | 64 | Second operand, four 16-bit lanes |
| accIn | input | 64 | Accumulator value |
| laneMask | input | 4 | One enable bit per lane of opA |
| doSub | input | 1 | 1: subtract the lane sum, 0: add it |
| outValid | output | 1 | Result valid |
| result | output | 64 | Registered accumulated result |

## Verification
The hardest case to reach is a lane sum whose top bit of the 32-bit product field is set. A sign-extension fault only shows up in that case, and only in the upper word. The stimulus drives 0xFFFF in one lane with the other lanes masked, and also all-ones in all four lanes with a zero accumulator. The upper 32 bits of the result then separate a correct widening from a sign-extended one. Subtract cases with a zero accumulator additionally exercise the wrap around 2^64.

// File: rtl/wdot_pkg.sv
package wdot_pkg;
  parameter int LANE_W = 16;
  parameter int LANES  = 4;
  parameter int ACC_W  = 64;
  localparam int OP_W  = LANE_W * LANES;

  typedef struct packed {
    logic load;
    logic sub;
    logic clear;
  } ctrlStrobe_t;
endpackage

// File: rtl/wdot_ctrl.sv
module wdot_ctrl
  import wdot_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        inValid,
  input  logic        doSub,
  output ctrlStrobe_t strobe,
  output logic        outValid
);
  always_comb begin
    strobe.load  = inValid & ~rst;
    strobe.sub   = doSub;
    strobe.clear = rst;
  end

  always_ff @(posedge clk) begin
    if (rst) outValid <= 1'b0;
    else     outValid <= inValid;
  end
endmodule

// File: rtl/wdot_lane.sv
module wdot_lane #(
  parameter int LANE_W = 16,
  parameter int ACC_W  = 64
) (
  input  logic [LANE_W-1:0] laneA,
  input  logic [LANE_W-1:0] laneB,
  input  logic              enable,
  output logic [ACC_W-1:0]  product
);
  logic [ACC_W-1:0] wideA;
  logic [ACC_W-1:0] wideB;

  always_comb begin
    wideA   = enable ? {{(ACC_W-LANE_W){1'b0}}, laneA} : '0;
    wideB   = {{(ACC_W-LANE_W){1'b0}}, laneB};
    product = wideA * wideB;
  end
endmodule

// File: rtl/wdot_dp.sv
module wdot_dp
  import wdot_pkg::*;
#(
  parameter int LW = LANE_W,
  parameter int NL = LANES,
  parameter int AW = ACC_W
) (
  input  logic             clk,
  input  ctrlStrobe_t      strobe,
  input  logic [LW*NL-1:0] opA,
  input  logic [LW*NL-1:0] opB,
  input  logic [AW-1:0]    accIn,
  input  logic [NL-1:0]    laneMask,
  output logic [AW-1:0]    result
);
  logic [AW-1:0] prod [NL];
  logic [AW-1:0] laneSum;
  logic [AW-1:0] nextVal;

  for (genvar k = 0; k < NL; k++) begin : g_lane
    wdot_lane #(.LANE_W(LW), .ACC_W(AW)) u_lane (
      .laneA  (opA[k*LW +: LW]),
      .laneB  (opB[k*LW +: LW]),
      .enable (laneMask[k]),
      .product(prod[k])
    );
  end

  always_comb begin
    laneSum = '0;
    for (int k = 0; k < NL; k++) laneSum = laneSum + prod[k];
    nextVal = strobe.sub ? (accIn - laneSum) : (accIn + laneSum);
  end

  always_ff @(posedge clk) begin
    if (strobe.clear)     result <= '0;
    else if (strobe.load) result <= nextVal;
  end
endmodule

// File: rtl/wdot_acc.sv
module wdot_acc
  import wdot_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          inValid,
  input  logic [63:0]   opA,
  input  logic [63:0]   opB,
  input  logic [63:0]   accIn,
  input  logic [3:0]    laneMask,
  input  logic          doSub,
  output logic          outValid,
  output logic [63:0]   result
);
  ctrlStrobe_t strobe;

  wdot_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .inValid (inValid),
    .doSub   (doSub),
    .strobe  (strobe),
    .outValid(outValid)
  );

  wdot_dp #(.LW(16), .NL(4), .AW(64)) u_dp (
    .clk     (clk),
    .strobe  (strobe),
    .opA     (opA),
    .opB     (opB),
    .accIn   (accIn),
    .laneMask(laneMask),
    .result  (result)
  );
endmodule

// File: rtl/wdot_acc_chk.sv
module wdot_acc_chk (
  input logic        clk,
  input logic        rst,
  input logic        inValid,
  input logic [63:0] opA,
  input logic [63:0] opB,
  input logic [63:0] accIn,
  input logic [3:0]  laneMask,
  input logic        doSub,
  input logic        outValid,
  input logic [63:0] result
);
  a_r6_valid_follows: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outValid);
  a_r6_valid_drops: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !outValid);
  a_r7_reset_clear: assert property (@(posedge clk)
    rst |=> (!outValid && result == 64'd0));
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> $stable(result));
  // R3 and R4: an all-masked issue passes the accumulator through unchanged
  a_r3_masked_passthru: assert property (@(posedge clk) disable iff (rst)
    (inValid && laneMask == 4'b0000) |=> (result == $past(accIn)));
  // R2: one active lane with a zero accumulator never fills the upper word
  a_r2_no_sign_ext: assert property (@(posedge clk) disable iff (rst)
    (inValid && !doSub && accIn == 64'd0 && $countones(laneMask) == 1)
      |=> (result[63:32] == 32'd0));
endmodule

bind wdot_acc wdot_acc_chk u_chk (.*);

// File: tb/wdot_acc_test.sv
module wdot_acc_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        inValid;
  logic [63:0] opA, opB, accIn;
  logic [3:0]  laneMask;
  logic        doSub;
  logic        outValid;
  logic [63:0] result;
  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  wdot_acc uut (.*);

  function automatic logic [63:0] refModel(input logic [63:0] a, input logic [63:0] b,
      input logic [63:0] acc, input logic [3:0] m, input logic s);
    logic [63:0] sum = 64'd0;
    for (int k = 0; k < 4; k++) begin
      logic [63:0] ea = m[k] ? {48'd0, a[16*k +: 16]} : 64'd0;
      logic [63:0] eb = {48'd0, b[16*k +: 16]};
      sum = sum + ea * eb;
    end
    return s ? acc - sum : acc + sum;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [63:0] a, input logic [63:0] b, input logic [63:0] acc,
      input logic [3:0] m, input logic s, input string req);
    @(negedge clk);
    opA = a; opB = b; accIn = acc; laneMask = m; doSub = s; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    check(req, {63'd0, outValid}, 64'd1);
    check(req, result, refModel(a, b, acc, m, s));
  endtask

  task automatic t_reset();
    rst = 1'b1; inValid = 1'b0; opA = '0; opB = '0; accIn = '0; laneMask = '0; doSub = 1'b0;
    repeat (2) @(negedge clk);
    check("R7", {63'd0, outValid}, 64'd0);
    check("R7", result, 64'd0);
    rst = 1'b0;
  endtask

  task automatic t_widen();
    issue(64'h0000_0000_0000_FFFF, 64'h0000_0000_0000_FFFF, 64'd0, 4'b0001, 1'b0, "R2");
    check("R2", result, 64'h0000_0000_FFFE_0001);
    issue('1, '1, 64'd0, 4'b1111, 1'b0, "R2");
    check("R2", result, 64'h0000_0003_FFF8_0004);
  endtask

  task automatic t_lanes();
    issue(64'h0004_0003_0002_0001, 64'h0010_0100_1000_0001, 64'd5, 4'b1111, 1'b0, "R1");
    check("R1", result, 64'd5 + 64'd1 + 64'h2000 + 64'h300 + 64'h40);
  endtask

  task automatic t_mask();
    issue('1, '1, 64'h1234, 4'b0000, 1'b0, "R3");
    check("R3", result, 64'h1234);
    issue('1, 64'h0001_0002_0003_0004, 64'd0, 4'b1010, 1'b0, "R3");
    check("R3", result, 64'hFFFF * 3 + 64'hFFFF * 1);
  endtask

  task automatic t_sub();
    issue(64'h0000_0000_0000_0003, 64'h0000_0000_0000_0007, 64'd100, 4'b0001, 1'b1, "R4");
    check("R4", result, 64'd79);
    issue(64'h0000_0000_0000_FFFF, 64'h0000_0000_0000_FFFF, 64'd0, 4'b0001, 1'b1, "R5");
    check("R5", result, 64'hFFFF_FFFF_0001_FFFF);
    issue(64'h0000_0000_0000_0002, 64'h0000_0000_0000_0001, '1, 4'b1111, 1'b0, "R5");
    check("R5", result, 64'd1);
  endtask

  task automatic t_hold();
    logic [63:0] prev;
    prev = result;
    opA = '1; opB = '1; accIn = 64'hABCD; laneMask = 4'hF;
    repeat (3) @(negedge clk);
    check("R8", result, prev);
    check("R6", {63'd0, outValid}, 64'd0);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_widen();
        t_lanes();
        t_mask();
        t_sub();
        t_hold();
      end
      begin
        repeat (5000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule